// File: doc/BRIEF.md
# R1B Busy Completion Synthesizer

This block sits beside an SD host controller whose own busy detection on the DAT0 line is unreliable. A command write is classified as it happens. A no-data command that expects a short response with busy arms one kind of fix. A data command whose transfer mode requests both multi-block and an automatic stop command arms the other. When the controller then raises its early completion interrupt, the block checks whether the card is still holding the data line busy.

If the card has already released the line, completion is reported at once. If it has not, the early interrupt is hidden and cleared out of the hardware status. The block then re-checks busy on each millisecond strobe. It reports either a synthetic data-end (plus the held-back response bit for the no-data case) or, once the timeout window runs out, a synthetic data-timeout.

Software sees the raw status merged with the synthetic bits. A write-one-to-clear to the status clears the matching synthetic bits and is also forwarded to the hardware clear path. An interrupt line is raised when any enabled merged bit is set.

Top module: `r1b_busy_fix`

## Requirements
- R1: After reset no fix is armed, no synthetic bit is set, `sts_o` equals `raw_status_i` and `hw_clr_o` is low unless software writes.
- R2: A command write with `cmd_has_data_i`=0 and `cmd_resp_type_i`=2'b11 arms the no-data fix. A command write with `cmd_has_data_i`=1 and both `xfer_acmd12_i` and `xfer_multi_i` set arms the stop-command fix. Any other command write disarms.
- R3: The trigger for the no-data fix is raw status bit 0 (response complete). The trigger for the stop-command fix is raw status bit 1 (data end). The other bit does not trigger.
- R4: The card counts as busy when `busy_line_active_i` or `data_inhibit_i` is high; either one alone is enough.
- R5: A trigger seen while not busy sets synthetic bit 1 in the next cycle, plus bit 0 for the no-data fix, and disarms the fix.
- R6: A trigger seen while busy pulses `hw_clr_o` in that cycle with the trigger bit in `hw_clr_mask_o`. The trigger bit is masked out of `sts_o` from that cycle until the outcome.
- R7: While waiting, each `ms_tick_i` re-checks busy. If the card is not busy, the release outcome of R5 is applied, including on the last tick of the window.
- R8: If the card is still busy on the TIMEOUT_MS-th tick, synthetic bit 20 (data timeout) is set instead of data end, and the fix is disarmed.
- R9: `sts_o` is the raw status OR the synthetic bits. A status write clears the synthetic bits under `sts_wdata_i` and drives `hw_clr_o` with that mask in the same cycle.
- R10: After an outcome, a further trigger bit in the raw status passes through with no action.
- R11: `irq_o` is high exactly when `sts_o & int_en_i` is non-zero.
- R12: Command writes while waiting for release have no effect on the armed fix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_has_data_i | input | 1 | Command carries a data phase |
| cmd_resp_type_i | input | 2 | Response type; 2'b11 is short with busy |
| xfer_acmd12_i | input | 1 | Transfer mode automatic stop command enable |
| xfer_multi_i | input | 1 | Transfer mode multi-block |
| raw_status_i | input | STS_W | Hardware interrupt status |
| busy_line_active_i | input | 1 | Data line active indication |
| data_inhibit_i | input | 1 | Data inhibit indication |
| ms_tick_i | input | 1 | One-cycle millisecond strobe |
| sts_wr_i | input | 1 | Software status write strobe |
| sts_wdata_i | input | STS_W | Write-one-to-clear mask |
| int_en_i | input | STS_W | Interrupt enable mask |
| sts_o | output | STS_W | Merged status seen by software |
| hw_clr_o | output | 1 | Clear strobe to hardware status |
| hw_clr_mask_o | output | STS_W | Bits to clear in hardware status |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the hardware status honours the clear path: a bit cleared through `hw_clr_o` does not reappear unless a new event raises it. They also assume `ms_tick_i` is a single-cycle strobe. The bench models the controller status as a register that it sets by explicit events and clears one edge after the expected clear mask. Ticks are always one-cycle pulses spaced by idle cycles. Busy indications change only at falling edges, and each change lasts for at least one whole cycle.

// File: rtl/r1b_fix_pkg.sv
package r1b_fix_pkg;
  typedef enum logic [1:0] {
    FIX_NONE   = 2'd0,
    FIX_NODATA = 2'd1,
    FIX_AC12   = 2'd2
  } fix_e;

  localparam logic [1:0] RESP_SHORT_BUSY = 2'b11;
endpackage

// File: rtl/r1b_cmd_classify.sv
module r1b_cmd_classify
  import r1b_fix_pkg::*;
(
  input  logic       has_data_i,
  input  logic [1:0] resp_type_i,
  input  logic       acmd12_i,
  input  logic       multi_i,
  output fix_e       fix_o
);
  always_comb begin
    fix_o = FIX_NONE;
    if (has_data_i) begin
      if (acmd12_i && multi_i) fix_o = FIX_AC12;
    end else if (resp_type_i == RESP_SHORT_BUSY) begin
      fix_o = FIX_NODATA;
    end
  end
endmodule

// File: rtl/r1b_busy_timer.sv
module r1b_busy_timer #(
  parameter int TIMEOUT_MS = 250,
  localparam int CW = $clog2(TIMEOUT_MS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          busy_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW:0] LIMIT = (CW+1)'(TIMEOUT_MS);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;
  logic          busy_tick;

  assign busy_tick = run_i && tick_i && busy_i;
  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign expire_o  = busy_tick && (cnt_inc >= LIMIT);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i)                cnt_q <= '0;
    else if (busy_tick && !expire_o) cnt_q <= cnt_inc[CW-1:0];
  end
endmodule

// File: rtl/r1b_synth_sts.sv
module r1b_synth_sts #(
  parameter int STS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_mask_i,
  input  logic [STS_W-1:0] clr_mask_i,
  input  logic [STS_W-1:0] raw_i,
  input  logic [STS_W-1:0] hide_mask_i,
  output logic [STS_W-1:0] sts_o
);
  logic [STS_W-1:0] synth_q;

  // clear first so a same-cycle event survives the write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) synth_q <= '0;
    else         synth_q <= (synth_q & ~clr_mask_i) | set_mask_i;
  end

  assign sts_o = (raw_i & ~hide_mask_i) | synth_q;
endmodule

// File: rtl/r1b_busy_fix.sv
module r1b_busy_fix
  import r1b_fix_pkg::*;
#(
  parameter int STS_W      = 32,
  parameter int RESP_BIT   = 0,
  parameter int DEND_BIT   = 1,
  parameter int DTO_BIT    = 20,
  parameter int TIMEOUT_MS = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic             cmd_has_data_i,
  input  logic [1:0]       cmd_resp_type_i,
  input  logic             xfer_acmd12_i,
  input  logic             xfer_multi_i,
  input  logic [STS_W-1:0] raw_status_i,
  input  logic             busy_line_active_i,
  input  logic             data_inhibit_i,
  input  logic             ms_tick_i,
  input  logic             sts_wr_i,
  input  logic [STS_W-1:0] sts_wdata_i,
  input  logic [STS_W-1:0] int_en_i,
  output logic [STS_W-1:0] sts_o,
  output logic             hw_clr_o,
  output logic [STS_W-1:0] hw_clr_mask_o,
  output logic             irq_o
);
  localparam int CW = $clog2(TIMEOUT_MS + 1);
  localparam logic [STS_W-1:0] RESP_M = STS_W'(1) << RESP_BIT;
  localparam logic [STS_W-1:0] DEND_M = STS_W'(1) << DEND_BIT;
  localparam logic [STS_W-1:0] DTO_M  = STS_W'(1) << DTO_BIT;

  fix_e             fix_q, fix_d, cmd_fix;
  logic             wait_q, wait_d;
  logic             busy, trig, hold_start, release_ev, timeout_ev;
  logic [STS_W-1:0] trig_m, hide_m, set_m, sw_clr_m;
  logic [CW-1:0]    ms_cnt;

  r1b_cmd_classify u_cls (
    .has_data_i  (cmd_has_data_i),
    .resp_type_i (cmd_resp_type_i),
    .acmd12_i    (xfer_acmd12_i),
    .multi_i     (xfer_multi_i),
    .fix_o       (cmd_fix)
  );

  assign busy       = busy_line_active_i | data_inhibit_i;
  assign trig_m     = (fix_q == FIX_NODATA) ? RESP_M : DEND_M;
  assign trig       = (fix_q != FIX_NONE) && !wait_q && |(raw_status_i & trig_m);
  assign hold_start = trig && busy;
  assign release_ev = (trig && !busy) || (wait_q && ms_tick_i && !busy);

  r1b_busy_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (hold_start),
    .run_i    (wait_q),
    .tick_i   (ms_tick_i),
    .busy_i   (busy),
    .expire_o (timeout_ev),
    .cnt_o    (ms_cnt)
  );

  always_comb begin
    fix_d  = fix_q;
    wait_d = wait_q;
    if (release_ev || timeout_ev) begin
      fix_d  = FIX_NONE;
      wait_d = 1'b0;
    end else if (hold_start) begin
      wait_d = 1'b1;
    end else if (!wait_q && !trig && cmd_wr_i) begin
      fix_d = cmd_fix;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fix_q  <= FIX_NONE;
      wait_q <= 1'b0;
    end else begin
      fix_q  <= fix_d;
      wait_q <= wait_d;
    end
  end

  always_comb begin
    set_m = '0;
    if (release_ev) begin
      set_m = DEND_M;
      if (fix_q == FIX_NODATA) set_m = set_m | RESP_M;
    end
    if (timeout_ev) set_m = DTO_M;
  end

  assign hide_m   = (hold_start || wait_q) ? trig_m : '0;
  assign sw_clr_m = sts_wr_i ? sts_wdata_i : '0;

  r1b_synth_sts #(.STS_W(STS_W)) u_sts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_mask_i  (set_m),
    .clr_mask_i  (sw_clr_m),
    .raw_i       (raw_status_i),
    .hide_mask_i (hide_m),
    .sts_o       (sts_o)
  );

  assign hw_clr_o      = sts_wr_i | hold_start;
  assign hw_clr_mask_o = sw_clr_m | (hold_start ? trig_m : '0);
  assign irq_o         = |(sts_o & int_en_i);
endmodule

// File: rtl/r1b_busy_fix_chk.sv
module r1b_busy_fix_chk #(
  parameter int STS_W      = 32,
  parameter int DEND_BIT   = 1,
  parameter int DTO_BIT    = 20,
  parameter int TIMEOUT_MS = 250,
  localparam int CW = $clog2(TIMEOUT_MS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wait_i,
  input logic [1:0]       fix_i,
  input logic [CW-1:0]    cnt_i,
  input logic             ms_tick_i,
  input logic             busy_line_active_i,
  input logic             data_inhibit_i,
  input logic             cmd_wr_i,
  input logic             sts_wr_i,
  input logic [STS_W-1:0] sts_wdata_i,
  input logic [STS_W-1:0] raw_status_i,
  input logic [STS_W-1:0] sts_o,
  input logic             hw_clr_o,
  input logic [STS_W-1:0] hw_clr_mask_o
);
  localparam logic [CW:0] LIMIT = (CW+1)'(TIMEOUT_MS);
  logic busy;
  assign busy = busy_line_active_i | data_inhibit_i;

  // R6
  hold_clears_hw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_i) |-> $past(hw_clr_o));

  // R7
  release_sets_dend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && ms_tick_i && !busy) |=> sts_o[DEND_BIT]);

  // R8
  timeout_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_status_i[DTO_BIT] && $rose(sts_o[DTO_BIT])) |-> $past(busy));

  // R8
  window_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i |-> ({1'b0, cnt_i} < LIMIT));

  // R9
  sw_write_forward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_i |-> (hw_clr_o && ((hw_clr_mask_o & sts_wdata_i) == sts_wdata_i)));

  // R10
  wait_needs_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i |-> (fix_i != 2'd0));

  // R12
  cmd_ignored_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && cmd_wr_i && !ms_tick_i) |=> $stable(fix_i));
endmodule

bind r1b_busy_fix r1b_busy_fix_chk #(
  .STS_W(STS_W), .DEND_BIT(DEND_BIT), .DTO_BIT(DTO_BIT), .TIMEOUT_MS(TIMEOUT_MS)
) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .wait_i             (wait_q),
  .fix_i              (fix_q),
  .cnt_i              (ms_cnt),
  .ms_tick_i          (ms_tick_i),
  .busy_line_active_i (busy_line_active_i),
  .data_inhibit_i     (data_inhibit_i),
  .cmd_wr_i           (cmd_wr_i),
  .sts_wr_i           (sts_wr_i),
  .sts_wdata_i        (sts_wdata_i),
  .raw_status_i       (raw_status_i),
  .sts_o              (sts_o),
  .hw_clr_o           (hw_clr_o),
  .hw_clr_mask_o      (hw_clr_mask_o)
);

// File: tb/r1b_busy_fix_test.sv
module r1b_busy_fix_test;
  localparam int T = 8;
  localparam logic [31:0] RESP = 32'h1;
  localparam logic [31:0] DEND = 32'h2;
  localparam logic [31:0] DTO  = 32'h0010_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_wr_i = 1'b0, cmd_has_data_i = 1'b0;
  logic [1:0]  cmd_resp_type_i = 2'b00;
  logic        xfer_acmd12_i = 1'b0, xfer_multi_i = 1'b0;
  logic [31:0] raw_status_i = '0;
  logic        busy_line_active_i = 1'b0, data_inhibit_i = 1'b0;
  logic        ms_tick_i = 1'b0, sts_wr_i = 1'b0;
  logic [31:0] sts_wdata_i = '0, int_en_i = 32'h3;
  logic [31:0] sts_o, hw_clr_mask_o;
  logic        hw_clr_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [31:0] hw_raw = '0;
  int          m_fix = 0, m_cnt = 0;
  bit          m_wait = 0;
  logic [31:0] m_synth = '0;

  always #10 clk_i = ~clk_i;

  r1b_busy_fix #(.TIMEOUT_MS(T)) uut (
    .clk_i, .rst_ni, .cmd_wr_i, .cmd_has_data_i, .cmd_resp_type_i,
    .xfer_acmd12_i, .xfer_multi_i, .raw_status_i, .busy_line_active_i,
    .data_inhibit_i, .ms_tick_i, .sts_wr_i, .sts_wdata_i, .int_en_i,
    .sts_o, .hw_clr_o, .hw_clr_mask_o, .irq_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] raw_set);
    logic busy, trig, rel, tmo, exp_clr;
    logic [31:0] tb, hide, exp_sts, exp_mask;
    hw_raw = hw_raw | raw_set;
    raw_status_i = hw_raw;
    #1;
    busy = busy_line_active_i | data_inhibit_i;
    tb = (m_fix == 1) ? RESP : DEND;
    trig = (m_fix != 0) && !m_wait && ((hw_raw & tb) != 0);
    hide = ((trig && busy) || m_wait) ? tb : 32'h0;
    exp_sts = (hw_raw & ~hide) | m_synth;
    exp_clr = sts_wr_i || (trig && busy);
    exp_mask = (sts_wr_i ? sts_wdata_i : 32'h0) | ((trig && busy) ? tb : 32'h0);
    chk(cur_req, "sts_o", sts_o, exp_sts);
    chk(cur_req, "hw_clr_o", {31'h0, hw_clr_o}, {31'h0, exp_clr});
    if (exp_clr) chk(cur_req, "hw_clr_mask_o", hw_clr_mask_o, exp_mask);
    chk("R11", "irq_o", {31'h0, irq_o}, {31'h0, ((exp_sts & int_en_i) != 0)});
    m_synth = m_synth & ~(sts_wr_i ? sts_wdata_i : 32'h0);
    rel = 0; tmo = 0;
    if (m_wait) begin
      if (ms_tick_i) begin
        if (!busy) rel = 1;
        else if (m_cnt + 1 >= T) tmo = 1;
        else m_cnt++;
      end
    end else if (trig) begin
      if (!busy) rel = 1;
      else begin m_wait = 1; m_cnt = 0; end
    end else if (cmd_wr_i) begin
      if (cmd_has_data_i) m_fix = (xfer_acmd12_i && xfer_multi_i) ? 2 : 0;
      else m_fix = (cmd_resp_type_i == 2'b11) ? 1 : 0;
    end
    if (rel) begin
      m_synth = m_synth | DEND | ((m_fix == 1) ? RESP : 32'h0);
      m_fix = 0; m_wait = 0;
    end
    if (tmo) begin m_synth = m_synth | DTO; m_fix = 0; m_wait = 0; end
    @(posedge clk_i); #1;
    if (exp_clr) hw_raw = hw_raw & ~exp_mask;
    raw_status_i = hw_raw;
    cmd_wr_i = 0; sts_wr_i = 0; ms_tick_i = 0;
    @(negedge clk_i);
  endtask

  task automatic cmd(input logic d, input logic [1:0] rt, input logic a12, input logic mb);
    cmd_wr_i = 1; cmd_has_data_i = d; cmd_resp_type_i = rt;
    xfer_acmd12_i = a12; xfer_multi_i = mb;
    step(0);
  endtask

  task automatic clear(input logic [31:0] m);
    sts_wr_i = 1; sts_wdata_i = m;
    step(0);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick_i = 1; step(0); step(0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    cur_req = "R1";
    step(0);
    chk("R1", "sts_o after reset", sts_o, 32'h0);
    step(32'h10);
    chk("R1", "raw passthrough", sts_o, 32'h10);
    clear(32'h10);

    // R5: no-data, not busy at trigger
    cur_req = "R5";
    cmd(0, 2'b11, 0, 0);
    step(RESP);
    chk("R5", "immediate release", sts_o, 32'h3);
    // R9
    cur_req = "R9";
    clear(32'h3);
    chk("R9", "w1c clears all", sts_o, 32'h0);

    // R4/R6/R7: busy via inhibit only
    cur_req = "R6";
    cmd(0, 2'b11, 0, 0);
    data_inhibit_i = 1;
    step(RESP);
    chk("R6", "trigger hidden", sts_o, 32'h0);
    cur_req = "R4";
    tick_n(3);
    chk("R4", "still waiting", sts_o, 32'h0);
    cur_req = "R7";
    data_inhibit_i = 0;
    tick_n(1);
    chk("R7", "release after ticks", sts_o, 32'h3);
    clear(32'h3);

    // R3/R8/R11: stop-command fix, busy via line active, timeout
    cur_req = "R3";
    cmd(1, 2'b10, 1, 1);
    step(RESP);
    chk("R3", "resp not a trigger for stop fix", sts_o, RESP);
    clear(RESP);
    busy_line_active_i = 1;
    int_en_i = DTO;
    cur_req = "R8";
    step(DEND);
    tick_n(T - 1);
    chk("R8", "no timeout before window", sts_o, 32'h0);
    chk("R11", "irq low", {31'h0, irq_o}, 32'h0);
    tick_n(1);
    chk("R8", "timeout bit", sts_o, DTO);
    chk("R11", "irq high on enabled bit", {31'h0, irq_o}, 32'h1);
    busy_line_active_i = 0;
    int_en_i = 32'h3;
    clear(DTO);

    // R7 boundary: release on last tick of window
    cur_req = "R7";
    cmd(1, 2'b00, 1, 1);
    busy_line_active_i = 1;
    step(DEND);
    tick_n(T - 1);
    busy_line_active_i = 0;
    tick_n(1);
    chk("R7", "release on last tick", sts_o, DEND);
    clear(DEND);

    // R2: non-arming commands
    cur_req = "R2";
    cmd(1, 2'b11, 0, 1);
    step(DEND);
    chk("R2", "multi only passes", sts_o, DEND);
    clear(DEND);
    cmd(0, 2'b10, 0, 0);
    data_inhibit_i = 1;
    step(RESP);
    chk("R2", "no-busy response passes", sts_o, RESP);
    data_inhibit_i = 0;
    clear(RESP);

    // R12: command write while waiting
    cur_req = "R12";
    cmd(0, 2'b11, 0, 0);
    data_inhibit_i = 1;
    step(RESP);
    cmd(1, 2'b00, 1, 1);
    data_inhibit_i = 0;
    tick_n(1);
    chk("R12", "fix kept no-data", sts_o, 32'h3);
    clear(32'h3);

    // R10: after outcome the trigger passes through
    cur_req = "R10";
    data_inhibit_i = 1;
    step(RESP);
    chk("R10", "no action when disarmed", sts_o, RESP);
    chk("R10", "no hw clear", {31'h0, hw_clr_o}, 32'h0);
    data_inhibit_i = 0;
    clear(RESP);
    step(0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule